// File: doc/BRIEF.md
# Write-Delivered Interrupt Aggregator

This block gathers a set of level interrupt inputs, records each low-to-high transition in a pending register and qualifies it with a mask into a request register. Each qualified event is not signalled on a wire. It is delivered to the processor as one single-beat 32-bit bus write. The target register supplies both parts of that write: its value with the low five bits cleared is the write address, and those five low bits are the write data.

Software reaches the block through a simple register port. That port takes 1- to 4-byte accesses within a word, with the byte lanes laid out big-endian, and answers every request one cycle later. A control bit that marks a bus error stops new events from being delivered while it is set, but the request register still records them. Deliveries that cannot go out at once wait in a queue that holds one entry per source, and they are issued in order of lowest source number first.

Top module: `irq_wrdeliv_ctrl`

## Requirements
- R1: After reset, the request, mask, pending and control registers read 0, the target register reads 0xFFFB0003, and no delivery write is issued.
- R2: A low-to-high transition on input n sets pending bit n whatever the mask holds. An input that stays high causes only one event.
- R3: When mask bit n is set at the moment input n rises, request bit n is set and one delivery write is queued. A mask write takes effect from the following cycle, so a rise in the same cycle as the write is judged against the old mask.
- R4: A delivery write carries address = target AND 0xFFFFFFE0 and data = target[4:0]. The address and data stay stable while the write waits for ready.
- R5: While control bit 0 (the bus-error bit) is set, rises on unmasked sources still set request bits but issue no delivery write, either then or later.
- R6: A read of the pending register (offset 0x08) returns its value and clears it. Any write to it clears it whatever the data or byte enables. A rise in the same cycle as such an access is kept.
- R7: The request register (offset 0x00) is read-only. A write to it is accepted without error and has no effect, and only reset clears it.
- R8: A read of the control register (offset 0x0C) returns bit 0 only. All other bits read 0.
- R9: The valid word offsets are request 0x00, mask 0x04, pending 0x08, control 0x0C and target 0x10. Any other offset, a non-word-aligned address, or all byte enables low gives an error response with read data 0 and changes no state. Every response comes the cycle after the request.
- R10: Byte enable bit i writes the byte at address offset i within the word, which is data bits [31-8i : 24-8i]. Bytes whose enable is low keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Level interrupt inputs |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the word accessed |
| bus_be | input | 4 | Byte enables, bit i = byte offset i (big-endian lanes) |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response valid, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| bus_rerr | output | 1 | Error response |
| m_valid | output | 1 | Delivery write request |
| m_addr | output | 32 | Delivery write address |
| m_data | output | 32 | Delivery write data |
| m_ready | input | 1 | Memory side accepts the delivery write |

## Verification
The hardest cases to reach from the ports are those where an input rises in the very cycle that a register access takes effect. Examples are a rise together with the mask write that would enable it, or a rise together with the pending access that clears it. The bench reaches these with one bus task that can raise input bits at the same falling edge that it presents the request, so both reach the same rising edge. The memory side's ready is throttled in a fixed pattern so that several queued deliveries wait in back-pressure, and the scoreboard checks their payload and number.

// File: rtl/irqwd_pkg.sv
package irqwd_pkg;
   localparam int WORD_W      = 32;
   localparam int PAYLOAD_W   = 5;
   localparam int CTL_ERR_BIT = 0;

   localparam logic [7:0] OFS_REQ  = 8'h00;
   localparam logic [7:0] OFS_MASK = 8'h04;
   localparam logic [7:0] OFS_PEND = 8'h08;
   localparam logic [7:0] OFS_CTL  = 8'h0C;
   localparam logic [7:0] OFS_TGT  = 8'h10;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_REQ,
      SEL_MASK,
      SEL_PEND,
      SEL_CTL,
      SEL_TGT
   } reg_sel_e;

   // big-endian byte lanes: enable i covers address offset i = bits [31-8i -: 8]
   function automatic logic [WORD_W-1:0] merge_be(input logic [WORD_W-1:0] old_v,
                                                  input logic [WORD_W-1:0] new_v,
                                                  input logic [3:0]        be);
      logic [WORD_W-1:0] r;
      r = old_v;
      for (int i = 0; i < 4; i++) begin
         if (be[i]) r[WORD_W-1-8*i -: 8] = new_v[WORD_W-1-8*i -: 8];
      end
      return r;
   endfunction
endpackage

// File: rtl/irqwd_edge.sv
module irqwd_edge #(
   parameter int NUM_SRC     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_i,
   output logic [NUM_SRC-1:0] rise_o
);
   logic [NUM_SRC-1:0] lvl;
   logic [NUM_SRC-1:0] prev;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("irqwd_edge: SYNC_STAGES must be 0..3");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = irq_i;
   end else begin : g_sync
      logic [NUM_SRC-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
         end else begin
            chain[0] <= irq_i;
            for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
         end
      end
      assign lvl = chain[SYNC_STAGES-1];
   end

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev[b] <= 1'b0;
         else        prev[b] <= lvl[b];
      end
      assign rise_o[b] = lvl[b] & ~prev[b];
   end

   // R2: a source cannot report a rise in two consecutive cycles
   a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irqwd_regs.sv
module irqwd_regs
   import irqwd_pkg::*;
#(
   parameter int              NUM_SRC   = 32,
   parameter int              AW        = 8,
   parameter logic [WORD_W-1:0] RESET_TGT = 32'hFFFB_0003
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [AW-1:0]      bus_addr,
   input  logic [3:0]         bus_be,
   input  logic [WORD_W-1:0]  bus_wdata,
   output logic               bus_rvalid,
   output logic [WORD_W-1:0]  bus_rdata,
   output logic               bus_rerr,
   input  logic [NUM_SRC-1:0] rise_i,
   output logic [NUM_SRC-1:0] post_o,
   output logic [WORD_W-1:0]  tgt_o
);
   localparam int PAD = WORD_W - NUM_SRC;

   logic [NUM_SRC-1:0] mask_q, pend_q, req_q;
   logic               err_q;
   logic [WORD_W-1:0]  tgt_q;

   reg_sel_e           sel;
   logic               hit;
   logic [WORD_W-1:0]  cur_word, merged;
   logic               wr_mask, wr_ctl, wr_tgt, pend_acc;

   if (AW < 5) begin : g_bad_aw
      $error("irqwd_regs: AW must be at least 5");
   end

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr[AW-1:5] == '0) begin
         unique case ({3'b000, bus_addr[4:0]})
            OFS_REQ:  sel = SEL_REQ;
            OFS_MASK: sel = SEL_MASK;
            OFS_PEND: sel = SEL_PEND;
            OFS_CTL:  sel = SEL_CTL;
            OFS_TGT:  sel = SEL_TGT;
            default:  sel = SEL_NONE;
         endcase
      end
   end

   assign hit = bus_req && (sel != SEL_NONE) && (bus_be != 4'b0000);

   always_comb begin
      unique case (sel)
         SEL_REQ:  cur_word = {{PAD{1'b0}}, req_q};
         SEL_MASK: cur_word = {{PAD{1'b0}}, mask_q};
         SEL_PEND: cur_word = {{PAD{1'b0}}, pend_q};
         SEL_CTL:  cur_word = WORD_W'(err_q) << CTL_ERR_BIT;
         SEL_TGT:  cur_word = tgt_q;
         default:  cur_word = '0;
      endcase
   end

   assign merged   = merge_be(cur_word, bus_wdata, bus_be);
   assign wr_mask  = hit && bus_we && (sel == SEL_MASK);
   assign wr_ctl   = hit && bus_we && (sel == SEL_CTL);
   assign wr_tgt   = hit && bus_we && (sel == SEL_TGT);
   assign pend_acc = hit && (sel == SEL_PEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
         bus_rerr   <= 1'b0;
      end else begin
         bus_rvalid <= bus_req;
         bus_rerr   <= bus_req && !hit;
         bus_rdata  <= (hit && !bus_we) ? cur_word : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pend_q <= '0;
         req_q  <= '0;
         err_q  <= 1'b0;
         tgt_q  <= RESET_TGT;
      end else begin
         if (wr_mask) mask_q <= merged[NUM_SRC-1:0];
         if (wr_ctl)  err_q  <= merged[CTL_ERR_BIT];
         if (wr_tgt)  tgt_q  <= merged;
         pend_q <= (pend_acc ? '0 : pend_q) | rise_i;
         req_q  <= req_q | (rise_i & mask_q);
      end
   end

   assign post_o = rise_i & mask_q & {NUM_SRC{~err_q}};
   assign tgt_o  = tgt_q;

   // R6: after a pending access only the rises of that cycle remain
   a_r6_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      pend_acc |=> (pend_q == $past(rise_i)));
   // R7: request bits never drop outside reset
   a_r7_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((req_q & $past(req_q)) == $past(req_q)));
   // R9: an error response carries no data
   a_r9_err_nodata: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rvalid && bus_rerr) |-> (bus_rdata == '0));
   // R9: a response follows every request by one cycle
   a_r9_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_rvalid);
endmodule

// File: rtl/irqwd_deliver.sv
module irqwd_deliver
   import irqwd_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] post_i,
   input  logic [WORD_W-1:0]  tgt_i,
   output logic               m_valid,
   output logic [WORD_W-1:0]  m_addr,
   output logic [WORD_W-1:0]  m_data,
   input  logic               m_ready
);
   logic [NUM_SRC-1:0] osd_q;
   logic [NUM_SRC-1:0] grant;
   logic               can_issue;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         logic found;
         found = 1'b0;
         grant = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (osd_q[i] && !found) begin
               grant[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         logic found;
         found = 1'b0;
         grant = '0;
         for (int i = NUM_SRC-1; i >= 0; i--) begin
            if (osd_q[i] && !found) begin
               grant[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end

   assign can_issue = !m_valid || m_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osd_q   <= '0;
         m_valid <= 1'b0;
         m_addr  <= '0;
         m_data  <= '0;
      end else begin
         osd_q <= (osd_q & ~(can_issue ? grant : '0)) | post_i;
         if (can_issue) begin
            m_valid <= |osd_q;
            if (|osd_q) begin
               m_addr <= {tgt_i[WORD_W-1:PAYLOAD_W], {PAYLOAD_W{1'b0}}};
               m_data <= {{(WORD_W-PAYLOAD_W){1'b0}}, tgt_i[PAYLOAD_W-1:0]};
            end
         end
      end
   end

   // R4: a stalled write holds its address and data
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data)));
   // R4: delivery address is 32-byte aligned
   a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_addr[PAYLOAD_W-1:0] == '0));
   // R4: at most one source chosen per issue
   a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R5: queue entries only appear from posted events
   a_r5_queue_source: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((osd_q & ~$past(osd_q) & ~$past(post_i)) == '0));
endmodule

// File: rtl/irq_wrdeliv_ctrl.sv
module irq_wrdeliv_ctrl
   import irqwd_pkg::*;
#(
   parameter int                NUM_SRC     = 32,
   parameter int                AW          = 8,
   parameter int                SYNC_STAGES = 0,
   parameter bit                LOW_FIRST   = 1'b1,
   parameter logic [WORD_W-1:0] RESET_TGT   = 32'hFFFB_0003
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_i,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [AW-1:0]      bus_addr,
   input  logic [3:0]         bus_be,
   input  logic [31:0]        bus_wdata,
   output logic               bus_rvalid,
   output logic [31:0]        bus_rdata,
   output logic               bus_rerr,
   output logic               m_valid,
   output logic [31:0]        m_addr,
   output logic [31:0]        m_data,
   input  logic               m_ready
);
   if (NUM_SRC < 1 || NUM_SRC > WORD_W) begin : g_bad_nsrc
      $error("irq_wrdeliv_ctrl: NUM_SRC must be 1..32");
   end

   logic [NUM_SRC-1:0] rise, post;
   logic [WORD_W-1:0]  tgt;

   irqwd_edge #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .rise_o(rise));

   irqwd_regs #(.NUM_SRC(NUM_SRC), .AW(AW), .RESET_TGT(RESET_TGT)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .bus_rerr(bus_rerr), .rise_i(rise), .post_o(post), .tgt_o(tgt));

   irqwd_deliver #(.NUM_SRC(NUM_SRC), .LOW_FIRST(LOW_FIRST)) u_dlv (
      .clk(clk), .rst_n(rst_n), .post_i(post), .tgt_i(tgt),
      .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data), .m_ready(m_ready));
endmodule

// File: tb/sim_irq_wrdeliv_ctrl.sv
module sim_irq_wrdeliv_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_i = '0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid, bus_rerr;
   logic [31:0] bus_rdata;
   logic        m_valid;
   logic [31:0] m_addr, m_data;
   logic        m_ready = 1'b0;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   bit stall_mode = 1'b0;
   int stall_cnt = 0;
   logic [63:0] exp_q[$];
   bit          held = 1'b0;
   logic [63:0] held_v;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_wrdeliv_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .bus_rerr(bus_rerr), .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data),
      .m_ready(m_ready));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: memory side with ready throttling, pops scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (held) begin
            chk(m_valid && ({m_addr, m_data} == held_v), "R4 stalled write stable",
                {m_addr, m_data}, held_v);
         end
         stall_cnt++;
         m_ready = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
         held    = m_valid && !m_ready;
         held_v  = {m_addr, m_data};
         if (m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected delivery", {m_addr, m_data}, 64'h0);
            end else begin
               logic [63:0] e;
               e = exp_q.pop_front();
               chk({m_addr, m_data} == e, "R4 delivery payload", {m_addr, m_data}, e);
            end
         end
      end
   end

   task automatic bus_op(input bit we, input logic [7:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, input logic [31:0] rise_bits,
                         output logic [31:0] rd, output logic er);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
      irq_i = irq_i | rise_bits;
      @(negedge clk);
      bus_req = 1'b0;
      rd = bus_rdata;
      er = bus_rerr;
      chk(bus_rvalid, "R9 response one cycle later", 64'(bus_rvalid), 64'h1);
   endtask

   task automatic wr(input logic [7:0] addr, input logic [3:0] be, input logic [31:0] wd,
                     input bit exp_err, input string req);
      logic [31:0] rd; logic er;
      bus_op(1'b1, addr, be, wd, 32'h0, rd, er);
      chk(er == exp_err, req, 64'(er), 64'(exp_err));
   endtask

   task automatic rdchk(input logic [7:0] addr, input logic [31:0] exp,
                        input bit exp_err, input string req);
      logic [31:0] rd; logic er;
      bus_op(1'b0, addr, 4'hF, 32'h0, 32'h0, rd, er);
      chk({er, rd} == {exp_err, exp}, req, 64'({er, rd}), 64'({exp_err, exp}));
   endtask

   task automatic pulse(input logic [31:0] bits, input int len);
      @(negedge clk);
      irq_i = irq_i | bits;
      repeat (len) @(negedge clk);
      irq_i = irq_i & ~bits;
   endtask

   task automatic drained(input string req);
      repeat (40) @(negedge clk);
      chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'h0);
   endtask

   initial begin
      logic [31:0] rd; logic er;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!m_valid, "R1 no delivery after reset", 64'(m_valid), 64'h0);
      rdchk(8'h00, 32'h0, 1'b0, "R1 request reset");
      rdchk(8'h04, 32'h0, 1'b0, "R1 mask reset");
      rdchk(8'h08, 32'h0, 1'b0, "R1 pending reset");
      rdchk(8'h0C, 32'h0, 1'b0, "R1 control reset");
      rdchk(8'h10, 32'hFFFB_0003, 1'b0, "R1 target reset");

      // R2 masked-off rise still pends, no delivery
      pulse(32'h2, 3);
      drained("R2 no delivery while masked");
      rdchk(8'h08, 32'h2, 1'b0, "R2 pending set unmasked");
      rdchk(8'h08, 32'h0, 1'b0, "R6 read clears pending");
      rdchk(8'h00, 32'h0, 1'b0, "R3 no request when masked");

      // R10 byte lanes
      wr(8'h04, 4'b1000, 32'h0000_0008, 1'b0, "R10 byte3 write ok");
      wr(8'h04, 4'b0001, 32'hFF12_3400, 1'b0, "R10 byte0 write ok");
      rdchk(8'h04, 32'hFF00_0008, 1'b0, "R10 big-endian lanes");
      wr(8'h04, 4'b1111, 32'h0000_0008, 1'b0, "R10 full write ok");

      // R3 R4 unmasked held-high source: exactly one delivery
      exp_q.push_back({32'hFFFB_0000, 32'h3});
      pulse(32'h8, 20);
      drained("R2 held input delivers once");
      rdchk(8'h00, 32'h8, 1'b0, "R3 request bit set");
      rdchk(8'h08, 32'h8, 1'b0, "R3 pending bit set");

      // R6 write clears regardless of data
      pulse(32'h2, 1);
      wr(8'h08, 4'b0001, 32'h0, 1'b0, "R6 pending write ok");
      rdchk(8'h08, 32'h0, 1'b0, "R6 write clears pending");

      // R6 rise in same cycle as pending read is kept
      bus_op(1'b0, 8'h08, 4'hF, 32'h0, 32'h4, rd, er);
      chk(rd == 32'h0, "R6 read returns old value", 64'(rd), 64'h0);
      irq_i[2] = 1'b0;
      rdchk(8'h08, 32'h4, 1'b0, "R6 same-cycle rise kept");

      // R3 mask write in same cycle as rise uses old mask
      bus_op(1'b1, 8'h04, 4'hF, 32'h28, 32'h20, rd, er);
      drained("R3 same-cycle mask not applied");
      rdchk(8'h00, 32'h8, 1'b0, "R3 old mask judged rise");
      @(negedge clk); irq_i[5] = 1'b0;
      exp_q.push_back({32'hFFFB_0000, 32'h3});
      pulse(32'h20, 2);
      drained("R3 delivery after mask active");
      rdchk(8'h00, 32'h28, 1'b0, "R3 request bit 5");

      // R7 request read-only
      wr(8'h00, 4'hF, 32'h0, 1'b0, "R7 write accepted");
      rdchk(8'h00, 32'h28, 1'b0, "R7 write ignored");

      // R8 control readback, R5 suppression
      wr(8'h0C, 4'hF, 32'hFFFF_FFFF, 1'b0, "R8 control write ok");
      rdchk(8'h0C, 32'h1, 1'b0, "R8 only bit0 reads");
      wr(8'h04, 4'hF, 32'h68, 1'b0, "R5 mask write ok");
      pulse(32'h40, 2);
      repeat (5) @(negedge clk);
      wr(8'h0C, 4'hF, 32'h0, 1'b0, "R5 control clear ok");
      drained("R5 no delivery under bus error");
      rdchk(8'h00, 32'h68, 1'b0, "R5 request still recorded");

      // R4 new target, several sources under back-pressure
      wr(8'h10, 4'hF, 32'h1234_567F, 1'b0, "R4 target write ok");
      rdchk(8'h10, 32'h1234_567F, 1'b0, "R4 target readback");
      wr(8'h04, 4'hF, 32'hF0, 1'b0, "R4 mask write ok");
      stall_mode = 1'b1;
      for (int k = 0; k < 4; k++) exp_q.push_back({32'h1234_5660, 32'h1F});
      pulse(32'hF0, 2);
      repeat (40) @(negedge clk);
      drained("R4 four queued deliveries");
      stall_mode = 1'b0;

      // R9 decode errors
      rdchk(8'h14, 32'h0, 1'b1, "R9 unmapped read error");
      wr(8'h14, 4'hF, 32'hDEAD_BEEF, 1'b1, "R9 unmapped write error");
      rdchk(8'h05, 32'h0, 1'b1, "R9 misaligned error");
      wr(8'h04, 4'b0000, 32'hFFFF_FFFF, 1'b1, "R9 empty byte enable error");
      rdchk(8'h04, 32'hF0, 1'b0, "R9 no state change on error");
      rdchk(8'h10, 32'h1234_567F, 1'b0, "R9 target untouched");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule